// File: doc/BRIEF.md
# Interleaved Memory Wait Controller

This block sits beside a memory that is split into two or four interleaved sections, with consecutive 32-bit words falling in successive sections. It watches the start of each bus cycle and decides whether that access needs a wait state. The memory's address is presented early. An access that moves to a different section from the previous one therefore has enough access time and finishes with no wait. An access that returns to the section it has just used has to wait.

The controller records the section, and the section-count setting, of the last accepted access. On each cycle-start strobe it compares the new section against that record. When the two match, it drives an active-low wait request for one clock. Reset clears the record, so the first access after reset never waits. The section-count input selects two sections, which are decoded from address bit 2, or four sections, which are decoded from address bits 3:2.

Top module: `ilv_wait_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `wait_n` is 1.
- R2: The section index comes from `sect_addr`, which carries address bits 3:2. With `four_sect`=1 the index is `sect_addr[1:0]`. With `four_sect`=0 the index is `sect_addr[0]` alone.
- R3: A strobed access whose section differs from the last recorded one leaves `wait_n` at 1 in the cycle after the strobe edge.
- R4: A strobed access to the same section as the last recorded one, under the same `four_sect` setting, drives `wait_n` to 0 in the cycle after the strobe edge.
- R5: `wait_n` is 0 for exactly one clock per matching access. In a cycle with no strobe, `wait_n` is 1 one cycle later.
- R6: The first strobed access after reset never waits, even if it reuses the section used before reset.
- R7: The recorded section changes only on a clock edge where `cyc_start` is 1. Addresses presented without the strobe have no effect on later decisions.
- R8: If `four_sect` differs between two consecutive accesses, the second one counts as a different section and does not wait.
- R9: With `four_sect`=0, `sect_addr[1]` is ignored. Two accesses that differ only in that bit hit the same section and wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_start | input | 1 | Start of a bus cycle, sampled on the rising edge |
| sect_addr | input | 2 | Address bits 3:2 of the access |
| four_sect | input | 1 | 1 selects four sections, 0 selects two |
| wait_n | output | 1 | Wait request, active low, registered |

## Verification
Each decision is registered once. `wait_n` therefore reflects the access strobed at one rising edge, and is valid from that edge until the next one. The bench drives inputs on falling edges and compares `wait_n` at the following falling edge. Every check then sees the result of exactly the access it just issued.

The bench sweeps every ordered pair of (section address, mode) accesses and puts an idle cycle between pairs, which covers the one-clock release. Directed sequences cover unstrobed addresses and a reset between two identical accesses.

// File: rtl/ilv_wait_pkg.sv
// Package: shared types for the interleaved wait controller.
// Assumes: at most four sections, so a section index is at most two bits.
package ilv_wait_pkg;

    // Number of sections in the current configuration
    typedef enum logic {
        SECT_TWO  = 1'b0,
        SECT_FOUR = 1'b1
    } sect_mode_e;

    // Address bits used to pick a section in two-section mode
    localparam int unsigned TWO_SECT_BITS = 1;

endpackage

// File: rtl/ilv_sect_decode.sv
// Module: turns the low word-address bits into a section index for the
// selected section count. Bits above the active width read as zero.
// Assumes: sel carries address bits starting at bit 2 (32-bit words).
module ilv_sect_decode
    import ilv_wait_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  logic [SEL_W-1:0] sel,
    input  sect_mode_e       mode,
    output logic [SEL_W-1:0] idx
);

    localparam int unsigned LOW_W = TWO_SECT_BITS;

    // One bit of index logic per select bit
    for (genvar b = 0; b < SEL_W; b++) begin : g_bit
        if (b < LOW_W) begin : g_always
            // Low bits take part in both modes
            assign idx[b] = sel[b];
        end else begin : g_four_only
            // Upper bits take part only with four sections
            assign idx[b] = (mode == SECT_FOUR) ? sel[b] : 1'b0;
        end
    end

endmodule

// File: rtl/ilv_sect_tracker.sv
// Module: holds the section and mode of the last strobed access and
// reports whether the current strobed access hits the same section.
// Assumes: the record is written only on edges where strobe is 1.
module ilv_sect_tracker
    import ilv_wait_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [SEL_W-1:0] idx,
    input  sect_mode_e       mode,
    output logic             hit
);

    logic [SEL_W-1:0] last_idx;
    sect_mode_e       last_mode;
    logic             last_vld;

    // Record the section of each strobed access; reset clears the record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vld  <= 1'b0;
            last_idx  <= '0;
            last_mode <= SECT_TWO;
        end else if (strobe) begin
            last_vld  <= 1'b1;
            last_idx  <= idx;
            last_mode <= mode;
        end
    end

    // Compare the incoming access against the record
    always_comb begin
        hit = strobe && last_vld && (idx == last_idx) && (mode == last_mode);
    end

endmodule

// File: rtl/ilv_wait_gen.sv
// Module: registers the wait request, active low, for one clock after a
// matching access edge.
// Assumes: hit is valid only while strobe is 1.
module ilv_wait_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic wait_n
);

    // Pull wait low in the cycle after a same-section strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_n <= 1'b1;
        end else begin
            wait_n <= !hit;
        end
    end

endmodule

// File: rtl/ilv_wait_ctrl.sv
// Module: top of the interleaved memory wait controller. It decodes the
// section of every strobed bus cycle and requests one wait state when two
// consecutive accesses land in the same section.
// Assumes: synchronous active-low reset; sect_addr holds address bits 3:2.
module ilv_wait_ctrl
    import ilv_wait_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic [SEL_W-1:0] sect_addr,
    input  logic             four_sect,
    output logic             wait_n
);

    sect_mode_e       mode;
    logic [SEL_W-1:0] idx;
    logic             hit;

    // Map the configuration pin onto the mode type
    always_comb begin
        mode = four_sect ? SECT_FOUR : SECT_TWO;
    end

    ilv_sect_decode #(.SEL_W(SEL_W)) u_dec (
        .sel  (sect_addr),
        .mode (mode),
        .idx  (idx)
    );

    ilv_sect_tracker #(.SEL_W(SEL_W)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cyc_start),
        .idx    (idx),
        .mode   (mode),
        .hit    (hit)
    );

    ilv_wait_gen u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .wait_n (wait_n)
    );

endmodule

// File: rtl/ilv_wait_ctrl_chk.sv
// Module: checker bound to the controller; relates strobes and the wait
// output at the ports over time.
// Assumes: the same reset as the controller.
module ilv_wait_ctrl_chk #(
    parameter int unsigned SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_start,
    input logic [SEL_W-1:0] sect_addr,
    input logic             four_sect,
    input logic             wait_n
);

    logic seen;

    // Mark that at least one access has been accepted since reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else if (cyc_start) seen <= 1'b1;
    end

    // R5
    wait_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_n |-> $past(cyc_start));

    // R5
    wait_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_n && !cyc_start) |=> wait_n);

    // R6
    first_access_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !seen) |=> wait_n);

    // R4
    same_sect_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && seen && $past(cyc_start) && four_sect && $past(four_sect)
         && sect_addr == $past(sect_addr)) |=> !wait_n);

    // R3
    alt_sect_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && seen && $past(cyc_start) && four_sect == $past(four_sect)
         && sect_addr[0] != $past(sect_addr[0])) |=> wait_n);

    // R8
    mode_change_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && seen && $past(cyc_start) && four_sect != $past(four_sect))
        |=> wait_n);

endmodule

bind ilv_wait_ctrl ilv_wait_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .sect_addr (sect_addr),
    .four_sect (four_sect),
    .wait_n    (wait_n)
);

// File: tb/tb_ilv_wait_ctrl.sv
module tb_ilv_wait_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic [1:0] sect_addr = 2'd0;
    logic       four_sect = 1'b0;
    logic       wait_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model of the record
    bit       m_vld = 0;
    bit [1:0] m_idx = 0;
    bit       m_mode = 0;

    always #10 clk = ~clk;

    ilv_wait_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .sect_addr (sect_addr),
        .four_sect (four_sect),
        .wait_n    (wait_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: wait_n=%b expected %b", tag, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, check at the next falling edge
    task automatic step(input logic s, input logic [1:0] a, input logic m,
                        input string tag);
        bit [1:0] idx;
        bit       hit;
        cyc_start = s;
        sect_addr = a;
        four_sect = m;
        idx = m ? a : {1'b0, a[0]};
        hit = s && m_vld && (idx == m_idx) && (m == m_mode);
        @(negedge clk);
        check(tag, wait_n, !hit);
        if (s) begin
            m_vld = 1;
            m_idx = idx;
            m_mode = m;
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        cyc_start = 0;
        @(negedge clk);
        check("R1 in reset", wait_n, 1'b1);
        @(negedge clk);
        rst_n = 1;
        m_vld = 0;
        step(0, 2'd0, 0, "R1 after reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R6: first access after reset does not wait
        step(1, 2'd1, 1, "R6 first access");

        // Exhaustive sweep over ordered pairs of (address, mode)
        for (int pm = 0; pm < 2; pm++)
            for (int pa = 0; pa < 4; pa++)
                for (int cm = 0; cm < 2; cm++)
                    for (int ca = 0; ca < 4; ca++) begin
                        string tag;
                        bit [1:0] pi, ci;
                        pi = pm[0] ? pa[1:0] : {1'b0, pa[0]};
                        ci = cm[0] ? ca[1:0] : {1'b0, ca[0]};
                        if (pm != cm) tag = "R8 mode change";
                        else if (pi != ci) tag = "R3 other section";
                        else if (cm == 0 && pa[1] != ca[1]) tag = "R9 bit3 ignored";
                        else if (cm == 0) tag = "R2 two-section same";
                        else tag = "R4 same section";
                        step(0, 2'd3, 1, "R5 idle release");
                        step(1, pa[1:0], pm[0], "R5 pair lead");
                        step(1, ca[1:0], cm[0], tag);
                    end

        // R2: four-section mode separates 0 and 2
        step(0, 2'd0, 1, "R5 idle");
        step(1, 2'd0, 1, "R2 lead");
        step(1, 2'd2, 1, "R2 four-section distinct");
        step(1, 2'd2, 1, "R4 repeat");
        step(1, 2'd2, 1, "R5 repeated hit");
        step(0, 2'd2, 1, "R5 released");

        // R7: unstrobed addresses leave the record alone
        step(1, 2'd1, 1, "R7 lead");
        step(0, 2'd3, 1, "R7 unstrobed");
        step(0, 2'd0, 0, "R7 unstrobed");
        step(1, 2'd1, 1, "R7 record kept");

        // R6: reset clears the record between two identical accesses
        step(1, 2'd2, 0, "R6 lead");
        do_reset();
        step(1, 2'd2, 0, "R6 after reset");
        step(1, 2'd2, 0, "R4 after reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule